// File: doc/BRIEF.md
# Synchronized Zero-Crossing Pulse Detector

This block watches a one-bit sign signal, meaning the polarity of some waveform, and produces a registered pulse one clock wide each time that polarity flips. The sign bit can come from two kinds of source. One is an analog comparator whose output is asynchronous to the clock. The other is the top bit of a sample stream from a converter that already runs on the block's clock. A select input picks the source. The comparator path goes through a multi-flop synchronizer. The converter path is captured by a single register.

The signal frequencies of interest are far below the clock rate, so a raw sign bit tends to chatter around zero. A persistence filter rejects this chatter: a new polarity is accepted only once it has differed from the accepted polarity for a programmable number of consecutive clocks. Edge logic then compares the accepted polarity with the value it held one clock earlier. Depending on the mode input, it reports rising crossings, falling crossings, both, or nothing. With every pulse it gives a direction flag.

Top module: `zcross_detect`

## Requirements
- R1: While `rst` is high, and after it falls until a crossing has actually been accepted, `zc_pulse` and `zc_dir` are 0. The first accepted sample after reset only seeds the stored polarity and never produces a pulse, whatever its value.
- R2: With `src_sel`=0 (converter source) and `hold_n` of 0 or 1, a sign change driven before clock edge k makes `zc_pulse` high for the cycle that follows edge k+2.
- R3: With `src_sel`=1 (comparator source), the same change appears exactly one cycle later than in R2, because of the extra synchronizer flop.
- R4: `mode_sel`=2'b00 reports only changes from 0 to 1 (0 is negative, 1 is positive), and `zc_dir` is 1 with each such pulse.
- R5: `mode_sel`=2'b01 reports only changes from 1 to 0, and `zc_dir` is 0 with each such pulse.
- R6: `mode_sel`=2'b10 reports changes in both directions. `zc_dir` equals the newly accepted polarity.
- R7: `mode_sel`=2'b11 suppresses every pulse.
- R8: With `hold_n`=N≥1, a new polarity is accepted only after it has differed from the accepted one on N consecutive clocks. A shorter excursion produces no pulse, and an accepted change is reported N−1 cycles later than in R2/R3.
- R9: `hold_n`=0 disables filtering. A sign glitch lasting one clock yields two pulses in consecutive cycles in mode 2'b10.
- R10: Each accepted polarity change that the mode selects produces exactly one cycle of `zc_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sign_in | input | 1 | Polarity bit: 1 positive, 0 negative |
| src_sel | input | 1 | 1 = asynchronous comparator source, 0 = clocked converter source |
| mode_sel | input | 2 | 00 rising, 01 falling, 10 both, 11 off |
| hold_n | input | HOLD_W (8) | Consecutive clocks a new polarity must persist; 0 disables filtering |
| zc_pulse | output | 1 | Registered crossing pulse, one clock wide |
| zc_dir | output | 1 | Direction with the pulse: 1 rising, 0 falling |

## Verification
The bench checks the exact cycle of each pulse on both source paths. A synchronizer that is missing, or that sits on the wrong path, shows up as a pulse one cycle early or late. Excursions one clock shorter than the hold count and exactly equal to it are both driven: an off-by-one counter would either let chatter through or swallow a real crossing. A reset with the sign held high catches a design that seeds its previous value with zero and fires a false rising pulse. A single-clock glitch in both-directions mode confirms that pulses in consecutive cycles are kept and not merged.

// File: rtl/zcd_pkg.sv
package zcd_pkg;
   typedef enum logic [1:0] {
      ZC_RISE = 2'b00,
      ZC_FALL = 2'b01,
      ZC_BOTH = 2'b10,
      ZC_OFF  = 2'b11
   } zc_mode_e;
endpackage

// File: rtl/zc_sign_frontend.sv
module zc_sign_frontend #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic sign_in,
   input  logic src_sel,
   output logic fe_sign,
   output logic fe_valid
);
   localparam int LAST = SYNC_STAGES - 1;

   logic [LAST:0] chain_q;
   logic [LAST:0] vld_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain_q[0] <= 1'b0;
         vld_q[0]   <= 1'b0;
      end else begin
         chain_q[0] <= sign_in;
         vld_q[0]   <= 1'b1;
      end
   end

   generate
      for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
         always_ff @(posedge clk) begin
            if (rst) begin
               chain_q[g] <= 1'b0;
               vld_q[g]   <= 1'b0;
            end else begin
               chain_q[g] <= chain_q[g-1];
               vld_q[g]   <= vld_q[g-1];
            end
         end
      end
   endgenerate

   // converter source is already clocked: one capture flop is enough
   always_comb begin
      if (src_sel) begin
         fe_sign  = chain_q[LAST];
         fe_valid = vld_q[LAST];
      end else begin
         fe_sign  = chain_q[0];
         fe_valid = vld_q[0];
      end
   end
endmodule

// File: rtl/zc_persist_filter.sv
module zc_persist_filter #(
   parameter int HOLD_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_sign,
   input  logic              in_valid,
   input  logic [HOLD_W-1:0] hold_n,
   output logic              filt_sign,
   output logic              filt_valid
);
   logic [HOLD_W-1:0] run_q;
   logic              last_run;

   // N = 0 and N = 1 both accept on the first differing sample
   assign last_run = (hold_n == '0) || (run_q == hold_n - 1'b1);

   always_ff @(posedge clk) begin
      if (rst) begin
         filt_sign  <= 1'b0;
         filt_valid <= 1'b0;
         run_q      <= '0;
      end else if (in_valid) begin
         if (!filt_valid) begin
            filt_sign  <= in_sign;
            filt_valid <= 1'b1;
            run_q      <= '0;
         end else if (in_sign == filt_sign) begin
            run_q <= '0;
         end else if (last_run) begin
            filt_sign <= in_sign;
            run_q     <= '0;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/zc_edge_unit.sv
module zc_edge_unit
   import zcd_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       cur_sign,
   input  logic       cur_valid,
   input  logic [1:0] mode_sel,
   output logic       pulse,
   output logic       dir
);
   logic prev_q;
   logic prev_vld_q;
   logic rise, fall, hit;

   assign rise = cur_sign & ~prev_q;
   assign fall = ~cur_sign & prev_q;

   always_comb begin
      unique case (zc_mode_e'(mode_sel))
         ZC_RISE: hit = rise;
         ZC_FALL: hit = fall;
         ZC_BOTH: hit = rise ^ fall;
         default: hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q     <= 1'b0;
         prev_vld_q <= 1'b0;
         pulse      <= 1'b0;
         dir        <= 1'b0;
      end else begin
         prev_q     <= cur_sign;
         prev_vld_q <= cur_valid;
         pulse      <= cur_valid & prev_vld_q & hit;
         dir        <= cur_valid & prev_vld_q & hit & cur_sign;
      end
   end
endmodule

// File: rtl/zcross_detect.sv
module zcross_detect #(
   parameter int HOLD_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sign_in,
   input  logic              src_sel,
   input  logic [1:0]        mode_sel,
   input  logic [HOLD_W-1:0] hold_n,
   output logic              zc_pulse,
   output logic              zc_dir
);
   initial begin
      assert (HOLD_W >= 1 && HOLD_W <= 16)
         else $error("HOLD_W out of range");
      assert (SYNC_STAGES >= 2 && SYNC_STAGES <= 4)
         else $error("SYNC_STAGES out of range");
   end

   logic fe_sign, fe_valid;
   logic filt_sign, filt_valid;

   zc_sign_frontend #(.SYNC_STAGES(SYNC_STAGES)) fe_i (
      .clk(clk), .rst(rst), .sign_in(sign_in), .src_sel(src_sel),
      .fe_sign(fe_sign), .fe_valid(fe_valid)
   );

   zc_persist_filter #(.HOLD_W(HOLD_W)) flt_i (
      .clk(clk), .rst(rst), .in_sign(fe_sign), .in_valid(fe_valid),
      .hold_n(hold_n), .filt_sign(filt_sign), .filt_valid(filt_valid)
   );

   zc_edge_unit edge_i (
      .clk(clk), .rst(rst), .cur_sign(filt_sign), .cur_valid(filt_valid),
      .mode_sel(mode_sel), .pulse(zc_pulse), .dir(zc_dir)
   );
endmodule

// File: rtl/zcd_checker.sv
module zcd_checker (
   input logic       clk,
   input logic       rst,
   input logic [1:0] mode_sel,
   input logic       zc_pulse,
   input logic       zc_dir,
   input logic       filt_sign,
   input logic       filt_valid,
   input logic       fe_sign
);
   // R1: reset leaves the outputs quiet on the following cycle
   a_r1_reset_quiet: assert property (@(posedge clk)
      rst |=> (!zc_pulse && !zc_dir));

   // R7: off mode never pulses
   a_r7_off_silent: assert property (@(posedge clk) disable iff (rst)
      ($past(mode_sel) == 2'b11) |-> !zc_pulse);

   // R4: rising-only mode reports direction 1
   a_r4_rise_dir: assert property (@(posedge clk) disable iff (rst)
      (zc_pulse && $past(mode_sel) == 2'b00) |-> zc_dir);

   // R5: falling-only mode reports direction 0
   a_r5_fall_dir: assert property (@(posedge clk) disable iff (rst)
      (zc_pulse && $past(mode_sel) == 2'b01) |-> !zc_dir);

   // R6: direction equals the accepted polarity that caused the pulse
   a_r6_dir_matches: assert property (@(posedge clk) disable iff (rst)
      zc_pulse |-> (zc_dir == $past(filt_sign)));

   // R8: the accepted polarity only ever moves to the incoming sample
   a_r8_accept_source: assert property (@(posedge clk) disable iff (rst)
      ($past(filt_valid) && !$stable(filt_sign)) |-> (filt_sign == $past(fe_sign)));

   // R10: no pulse before a polarity has been accepted
   a_r10_needs_seed: assert property (@(posedge clk) disable iff (rst)
      !filt_valid |-> !zc_pulse);
endmodule

bind zcross_detect zcd_checker chk_i (
   .clk(clk), .rst(rst), .mode_sel(mode_sel), .zc_pulse(zc_pulse),
   .zc_dir(zc_dir), .filt_sign(filt_sign), .filt_valid(filt_valid),
   .fe_sign(fe_sign)
);

// File: tb/zcross_detect_tb_top.sv
module zcross_detect_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WIN = 30;

   typedef struct packed {
      logic       src;
      logic [1:0] mode;
      logic [7:0] hold;
      logic [7:0] len;
      logic [3:0] cnt;
      logic [7:0] first;
      logic       dir;
      logic [7:0] last;
   } vec_t;

   // sign rises at t=0 and falls at t=len; t counts negedges
   localparam vec_t VECS [10] = '{
      '{1'b0, 2'b00, 8'd0, 8'd5, 4'd1, 8'd3,  1'b1, 8'd3},  // R2 R4
      '{1'b0, 2'b01, 8'd0, 8'd5, 4'd1, 8'd8,  1'b0, 8'd8},  // R5
      '{1'b0, 2'b10, 8'd0, 8'd5, 4'd2, 8'd3,  1'b1, 8'd8},  // R6
      '{1'b1, 2'b00, 8'd0, 8'd5, 4'd1, 8'd4,  1'b1, 8'd4},  // R3
      '{1'b0, 2'b11, 8'd0, 8'd5, 4'd0, 8'd0,  1'b0, 8'd0},  // R7
      '{1'b0, 2'b00, 8'd3, 8'd2, 4'd0, 8'd0,  1'b0, 8'd0},  // R8 short
      '{1'b0, 2'b00, 8'd3, 8'd3, 4'd1, 8'd5,  1'b1, 8'd5},  // R8 exact
      '{1'b1, 2'b10, 8'd4, 8'd6, 4'd2, 8'd7,  1'b1, 8'd13}, // R8 R3
      '{1'b0, 2'b10, 8'd0, 8'd1, 4'd2, 8'd3,  1'b1, 8'd4},  // R9 R10
      '{1'b0, 2'b00, 8'd1, 8'd1, 4'd1, 8'd3,  1'b1, 8'd3}   // R8 N=1
   };

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       sign_in = 1'b0;
   logic       src_sel = 1'b0;
   logic [1:0] mode_sel = 2'b00;
   logic [7:0] hold_n = 8'd0;
   logic       zc_pulse, zc_dir;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   zcross_detect dut_i (
      .clk(clk), .rst(rst), .sign_in(sign_in), .src_sel(src_sel),
      .mode_sel(mode_sel), .hold_n(hold_n), .zc_pulse(zc_pulse), .zc_dir(zc_dir)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic run_vec(input vec_t v, input string tag);
      int cnt, first, last, dfirst;
      cnt = 0; first = 0; last = 0; dfirst = 0;
      @(negedge clk);
      src_sel = v.src; mode_sel = v.mode; hold_n = v.hold; sign_in = 1'b0;
      idle(12);
      sign_in = 1'b1;
      for (int t = 1; t <= WIN; t++) begin
         @(negedge clk);
         if (zc_pulse) begin
            if (cnt == 0) begin first = t; dfirst = int'(zc_dir); end
            last = t;
            cnt++;
         end
         if (t == int'(v.len)) sign_in = 1'b0;
      end
      check({tag, " count"}, cnt, int'(v.cnt));
      if (v.cnt != 0) begin
         check({tag, " first"}, first, int'(v.first));
         check({tag, " dir"}, dfirst, int'(v.dir));
         check({tag, " last"}, last, int'(v.last));
      end
   endtask

   initial begin
      int hits;
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 pulse in reset", int'(zc_pulse), 0);
      check("R1 dir in reset", int'(zc_dir), 0);
      rst = 1'b0;

      for (int i = 0; i < 10; i++) run_vec(VECS[i], $sformatf("vec%0d", i));

      // R1: reset with the sign held high must not fire on the seed sample
      @(negedge clk);
      rst = 1'b1; mode_sel = 2'b10; src_sel = 1'b0; hold_n = 8'd0; sign_in = 1'b1;
      idle(3);
      rst = 1'b0;
      hits = 0;
      for (int t = 0; t < 10; t++) begin
         @(negedge clk);
         if (zc_pulse) hits++;
      end
      check("R1 seed high no pulse", hits, 0);
      // R5: following fall is reported with direction 0
      mode_sel = 2'b01; sign_in = 1'b0;
      idle(3);
      check("R5 fall after seed", int'(zc_pulse), 1);
      check("R5 fall dir", int'(zc_dir), 0);
      @(negedge clk);
      check("R10 single width", int'(zc_pulse), 0);

      // R1: comparator path seeded low, no pulse
      rst = 1'b1; src_sel = 1'b1; mode_sel = 2'b10; sign_in = 1'b0;
      idle(2);
      rst = 1'b0;
      hits = 0;
      for (int t = 0; t < 8; t++) begin
         @(negedge clk);
         if (zc_pulse) hits++;
      end
      check("R1 comparator seed", hits, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule